// File: doc/BRIEF.md
# Serial-Input Converter Code Register

This block is the digital front end of a 16-bit voltage-output converter. A host writes a code over a three-wire serial link made of an active-low select, a serial clock and a data line. The block shifts the bits into a staging register and, once a complete word has arrived, copies it into the code latch that drives the converter ladder. All three serial lines are oversampled in the system clock domain. The system clock must run at least four times faster than the serial clock.

The code latch has two fixed starting values. The unipolar build starts at code zero and the bipolar build starts at midscale (0x8000). The latch takes this value when power-on reset is applied and whenever the active-low clear line is pulled low. The clear acts at once, without waiting for a clock edge, and does not depend on anything happening on the serial link. A one-cycle strobe marks every change of the latch. A separate one-cycle error pulse marks a frame that closed with the wrong number of bits; such a frame leaves the latch as it was.

Top module: `sdac_front`

## Requirements
- R1: While power-on reset is low, `code` holds the starting value: 0x0000 when `BIPOLAR`=0, and 0x8000 (bit 15 set, all other bits clear) when `BIPOLAR`=1. After reset is released, `updStrobe` pulses high for exactly one clock.
- R2: A frame opens on the falling edge of `csN`. While `csN` is low, one bit of `sdi` is taken on each rising edge of `sclk`. Bits arrive most significant first. When a frame of exactly 16 bits closes, `code` equals that word, and in the same cycle `updStrobe` is high for one clock.
- R3: `code` changes only after `csN` rises. Once all 16 bits have been shifted in, `code` still holds its previous value for as long as `csN` stays low.
- R4: A frame that closes after fewer than 16 bits, including zero bits, leaves `code` unchanged. No `updStrobe` is raised, and `frameErr` is high for exactly one clock.
- R5: A frame that closes after more than 16 bits leaves `code` unchanged, with the same one-clock `frameErr` pulse and no `updStrobe`.
- R6: Pulling `clrN` low forces `code` to the starting value from R1 before the next clock edge, whatever the state of the serial link.
- R7: A clear that arrives while `csN` is low throws away the bits received so far and restarts the bit count. A frame of 16 bits sent after the clear, under the same low `csN`, is then loaded on the `csN` rise.
- R8: `updStrobe` is high for exactly one clock for each change of the latch: a transfer, or the release of clear or reset. It never stays high for two clocks in a row.
- R9: Edges on `sclk` while `csN` is high change nothing. Neither `code`, `updStrobe` nor `frameErr` responds to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| clrN | input | 1 | Asynchronous active-low clear of the code latch |
| csN | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial bit clock; data is taken on its rising edge |
| sdi | input | 1 | Serial data, MSB first |
| code | output | 16 | Latched converter code |
| updStrobe | output | 1 | One-clock pulse when `code` takes a new value |
| frameErr | output | 1 | One-clock pulse when a frame closes with the wrong bit count |

## Verification
The bench sends short frames, empty frames and frames with 17 bits, and checks that none of them moves the latch. A design that checked only for "at least 16 bits", or that let its counter wrap, would load a shifted word in these cases. The bench also holds `csN` low for a long time after the sixteenth bit. A latch that updated on the bit count alone would show the new code too early. Two cases target the clear. The first samples `code` within two nanoseconds of the clear falling, which catches a clear that waits for a clock edge. The second clears in the middle of a frame and then sends a full word. If the count survived the clear, that word would be rejected. Clock edges sent while `csN` is high must produce no events at all, and a bipolar instance sharing the same inputs confirms the midscale start value.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  // Per-cycle commands from control to datapath.
  typedef struct packed {
    logic shiftEn;  // take one serial bit into the staging register
    logic loadEn;   // copy staging register into the code latch
  } sdacCtl_t;
endpackage

// File: rtl/sdac_ctrl.sv
module sdac_ctrl
  import sdac_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     initN,
  input  logic     csN,
  input  logic     sclk,
  input  logic     sdi,
  output sdacCtl_t ctl,
  output logic     sdiS,
  output logic     frameErr
);
  localparam int CNT_W = $clog2(WORD_W) + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic [SYNC_STAGES-1:0] csPipe, sclkPipe, sdiPipe;
  logic csS, sclkS, csPrev, sclkPrev;
  logic csFall, csRise, sclkRise;
  logic [CNT_W-1:0] bitCnt;

  // Synchronisers run on power-on reset only; a clear leaves them alone.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe   <= '1;
      sclkPipe <= '0;
      sdiPipe  <= '0;
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csPipe   <= {csPipe[SYNC_STAGES-2:0], csN};
      sclkPipe <= {sclkPipe[SYNC_STAGES-2:0], sclk};
      sdiPipe  <= {sdiPipe[SYNC_STAGES-2:0], sdi};
      csPrev   <= csS;
      sclkPrev <= sclkS;
    end
  end

  assign csS      = csPipe[SYNC_STAGES-1];
  assign sclkS    = sclkPipe[SYNC_STAGES-1];
  assign sdiS     = sdiPipe[SYNC_STAGES-1];
  assign csFall   = csPrev & ~csS;
  assign csRise   = ~csPrev & csS;
  assign sclkRise = ~sclkPrev & sclkS;

  always_comb begin
    ctl.shiftEn = sclkRise & ~csS;
    ctl.loadEn  = csRise & (bitCnt == FULL);
  end

  // Bit counter saturates so that long frames cannot wrap back to 16.
  always_ff @(posedge clk or negedge initN) begin
    if (!initN) begin
      bitCnt   <= '0;
      frameErr <= 1'b0;
    end else begin
      frameErr <= csRise & (bitCnt != FULL);
      if (csFall)
        bitCnt <= '0;
      else if (ctl.shiftEn && bitCnt != '1)
        bitCnt <= bitCnt + 1'b1;
    end
  end

  // R2
  frame_start_chk: assert property (@(posedge clk) disable iff (!initN)
    csFall |=> (bitCnt == '0));

  // R4
  err_single_chk: assert property (@(posedge clk) disable iff (!initN)
    frameErr |=> !frameErr);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!initN)
    (csS && csPrev && !csFall) |=> $stable(bitCnt));
endmodule

// File: rtl/sdac_path.sv
module sdac_path
  import sdac_pkg::*;
#(
  parameter int              WORD_W    = 16,
  parameter logic [WORD_W-1:0] INIT_CODE = '0
) (
  input  logic              clk,
  input  logic              initN,
  input  sdacCtl_t          ctl,
  input  logic              sdiS,
  output logic [WORD_W-1:0] code,
  output logic              updStrobe
);
  logic [WORD_W-1:0] shiftReg;
  logic              pendInit;

  // Staging register: cleared by reset or clear, MSB enters first.
  always_ff @(posedge clk or negedge initN) begin
    if (!initN)
      shiftReg <= '0;
    else if (ctl.shiftEn)
      shiftReg <= {shiftReg[WORD_W-2:0], sdiS};
  end

  // Code latch with asynchronous forcing to the starting value.
  always_ff @(posedge clk or negedge initN) begin
    if (!initN) begin
      code      <= INIT_CODE;
      pendInit  <= 1'b1;
      updStrobe <= 1'b0;
    end else begin
      pendInit  <= 1'b0;
      updStrobe <= pendInit | ctl.loadEn;
      if (ctl.loadEn)
        code <= shiftReg;
    end
  end

  // R1
  init_value_chk: assert property (@(posedge clk) disable iff (!initN)
    pendInit |-> (code == INIT_CODE));

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (!initN)
    ctl.loadEn |=> (code == $past(shiftReg)));

  // R3
  hold_unless_load_chk: assert property (@(posedge clk) disable iff (!initN)
    (!ctl.loadEn && !pendInit) |=> $stable(code));

  // R8
  strobe_single_chk: assert property (@(posedge clk) disable iff (!initN)
    updStrobe |=> !updStrobe);
endmodule

// File: rtl/sdac_front.sv
module sdac_front
  import sdac_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter bit BIPOLAR     = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clrN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  output logic [WORD_W-1:0] code,
  output logic              updStrobe,
  output logic              frameErr
);
  localparam logic [WORD_W-1:0] INIT_CODE =
    BIPOLAR ? {1'b1, {(WORD_W-1){1'b0}}} : '0;

  sdacCtl_t ctl;
  logic     sdiS;
  logic     initN;

  assign initN = rstN & clrN;

  sdac_ctrl #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .initN(initN), .csN(csN), .sclk(sclk),
    .sdi(sdi), .ctl(ctl), .sdiS(sdiS), .frameErr(frameErr)
  );

  sdac_path #(.WORD_W(WORD_W), .INIT_CODE(INIT_CODE)) u_path (
    .clk(clk), .initN(initN), .ctl(ctl), .sdiS(sdiS),
    .code(code), .updStrobe(updStrobe)
  );
endmodule

// File: tb/sdac_front_tb.sv
module sdac_front_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0, clrN = 1'b1, csN = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [15:0] code, codeB;
  logic updStrobe, frameErr, updB, errB;

  always #2 clk = ~clk;  // 250 MHz

  sdac_front #(.BIPOLAR(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .clrN(clrN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .code(code), .updStrobe(updStrobe), .frameErr(frameErr));

  sdac_front #(.BIPOLAR(1'b1)) u_dutB (
    .clk(clk), .rstN(rstN), .clrN(clrN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .code(codeB), .updStrobe(updB), .frameErr(errB));

  typedef struct { bit isErr; logic [15:0] code; } exp_t;
  exp_t expQ[$];
  int nRun = 0, nFail = 0;
  logic [15:0] curCode = 16'h0000;

  task automatic chk(string req, logic [15:0] act, logic [15:0] expv);
    nRun++;
    if (act !== expv) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic pushExp(bit isErr, logic [15:0] c);
    exp_t e;
    e.isErr = isErr;
    e.code  = c;
    expQ.push_back(e);
  endtask

  // Scoreboard monitor: every event pops one expected item.
  always @(negedge clk) begin
    if (updStrobe === 1'b1 || frameErr === 1'b1) begin
      if (expQ.size() == 0) begin
        chk("R8 unexpected event", {14'd0, updStrobe, frameErr}, 16'd0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        if (e.isErr) begin
          chk("R4 error pulse", {14'd0, updStrobe, frameErr}, 16'd1);
          chk("R4 code held", code, e.code);
        end else begin
          chk("R8 strobe", {14'd0, updStrobe, frameErr}, 16'd2);
          chk("R2 latched code", code, e.code);
        end
      end
    end
  end

  task automatic sendBits(logic [31:0] bits, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i];
      #16 sclk = 1'b1;
      #16 sclk = 1'b0;
    end
  endtask

  task automatic frame(logic [31:0] bits, int n);
    csN = 1'b0;
    #20;
    sendBits(bits, n);
    #20;
    if (n == 16) begin
      curCode = bits[15:0];
      pushExp(1'b0, curCode);
    end else begin
      pushExp(1'b1, curCode);
    end
    csN = 1'b1;
    #100;
  endtask

  task automatic clearPulse();
    @(posedge clk);
    #1 clrN = 1'b0;
    #1;
    chk("R6 async clear unipolar", code, 16'h0000);
    chk("R6 async clear bipolar", codeB, 16'h8000);
    curCode = 16'h0000;
    pushExp(1'b0, 16'h0000);
    #40 clrN = 1'b1;
    #100;
  endtask

  initial begin
    #400000;
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #10;
    chk("R1 reset unipolar", code, 16'h0000);
    chk("R1 reset bipolar", codeB, 16'h8000);
    pushExp(1'b0, 16'h0000);
    @(posedge clk);
    #1 rstN = 1'b1;
    #100;

    frame(32'h0000A5C3, 16);          // R2
    chk("R2 bipolar shares load", codeB, 16'hA5C3);
    frame(32'h0000FFFF, 16);          // R2
    frame(32'h00000001, 16);          // R2

    // R3: all bits in, csN held low, latch must not move yet
    csN = 1'b0;
    #20;
    sendBits(32'h00001234, 16);
    #200;
    chk("R3 hold before csN rise", code, curCode);
    curCode = 16'h1234;
    pushExp(1'b0, curCode);
    csN = 1'b1;
    #100;
    chk("R3 loaded after rise", code, 16'h1234);

    frame(32'h000003FF, 10);          // R4 short
    frame(32'h00000000, 0);           // R4 empty
    frame(32'h0001BEEF, 17);          // R5 long
    chk("R5 code kept", code, 16'h1234);

    // R9: clock activity while deselected
    for (int k = 0; k < 6; k++) begin
      sdi = k[0];
      #16 sclk = 1'b1;
      #16 sclk = 1'b0;
    end
    #100;
    chk("R9 code unchanged", code, 16'h1234);
    chk("R9 no pending events", 16'(expQ.size()), 16'd0);

    clearPulse();                     // R6
    chk("R6 bipolar after clear", codeB, 16'h8000);

    // R7: clear in the middle of a frame, then a full word
    csN = 1'b0;
    #20;
    sendBits(32'h000000AA, 8);
    clearPulse();
    sendBits(32'h00005A3C, 16);
    #20;
    curCode = 16'h5A3C;
    pushExp(1'b0, curCode);
    csN = 1'b1;
    #100;
    chk("R7 word after mid-frame clear", code, 16'h5A3C);

    frame(32'h00008001, 16);          // R2
    #200;
    chk("R8 all events seen", 16'(expQ.size()), 16'd0);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule